// File: doc/BRIEF.md
# Memory Protection Region Unit

This block checks memory accesses against a small set of programmable address windows. Each window has an inclusive lower and upper bound on 32-byte boundaries, a permission code, an execute-never flag, a shareability tag and a 3-bit index into a table of eight memory-attribute bytes. Software programs the windows through a word-addressed 32-bit register port. One selector register picks which window the main base/limit pair reaches. Three further base/limit pairs reach neighbouring windows without a rewrite of the selector.

The lookup side is purely combinational. It takes an access address and four qualifiers: privileged, write, instruction fetch and negative-priority handler. It returns a fault flag, a hit flag, the number of the single matching window and that window's attribute byte. A global control register can bypass the unit entirely. It can also bypass the unit only for negative-priority handlers, and it can let privileged accesses that match no window through on the default map.

Top module: `prot_region_unit`

## Requirements
- R1: After reset every register reads zero except offset 0x00, which always reads 0x0000_0800 (bits [15:8] = window count 8, bit 0 = 0 for no split instruction/data windows) and ignores writes.
- R2: Offset 0x04 holds bit 0 = unit enable, bit 1 = check during negative-priority handlers, bit 2 = privileged default-map fallback; bits [31:3] read zero.
- R3: Offset 0x08 holds the window selector in bits [2:0]; its other bits read zero and ignore writes.
- R4: Offset 0x0C reaches the selected window's base word: [31:5] bound bits, [4:3] shareability, [2:1] permission, [0] execute-never, all read back as written. Offset 0x10 reaches its limit word: [31:5] bound bits, [3:1] attribute index, [0] window enable; bit 4 reads zero.
- R5: Offsets 0x14/0x18, 0x1C/0x20 and 0x24/0x28 are base/limit pairs for alias n = 1, 2, 3; they reach window {selector[2], n[1:0]}.
- R6: Offsets 0x30 and 0x34 hold attribute bytes; index k selects byte k of {0x34 word, 0x30 word}, so indices 0-3 come from 0x30 low byte first and 4-7 from 0x34.
- R7: An enabled window matches when {base[31:5],5'b00000} <= address <= {limit[31:5],5'b11111}; a single match gives hit = 1, the window number and its attribute byte.
- R8: With the unit enable clear, every access is allowed: fault = 0, hit = 0, region = 0, attribute = 0.
- R9: With the negative-priority input high and control bit 1 clear, the result is as in R8.
- R10: When no enabled window matches, a privileged access with control bit 2 set is allowed and any other access faults; hit, region and attribute are zero.
- R11: When two or more enabled windows match, the access faults with hit, region and attribute zero.
- R12: On a single match, the permission field (bit 2 set = read-only, bit 1 set = unprivileged allowed) and execute-never decide the fault: a write to read-only, an unprivileged access without bit 1, or a fetch with execute-never set faults. Hit, region and attribute are still reported.
- R13: Offset 0x2C and offsets at or above 0x38 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset (bits [1:0] ignored) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| acc_addr | input | 32 | Access address to check |
| acc_priv | input | 1 | Access is privileged |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_negpri | input | 1 | Access comes from a negative-priority handler |
| acc_fault | output | 1 | Access is refused |
| acc_hit | output | 1 | Exactly one enabled window matched |
| acc_region | output | 3 | Matching window number |
| acc_attr | output | 8 | Attribute byte of the matching window |

## Verification
The bench probes addresses one byte on either side of each bound. A design that drops the appended 0x1F or uses an exclusive limit loses the last 31 bytes of a window or gains the next byte. Alias writes are issued with the selector's low bits set to junk. An alias decode that uses the whole selector lands in the wrong window, and the lookup then reports the wrong number or a miss. Overlapping random windows check that a multiple match faults rather than picking a winner. Every attribute index is exercised, to catch byte-order or register-swap mistakes in the attribute table. Random permission, fetch and privilege mixes are used to expose an inverted permission bit.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam logic [31:0] LIM_WMASK = 32'hFFFF_FFEF;

    typedef struct packed {
        logic       priv_bg;
        logic       neg_en;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic [26:0] bound;
        logic [1:0]  share;
        logic [1:0]  perm;
        logic        xn;
    } base_word_t;

    typedef struct packed {
        logic [26:0] bound;
        logic        rsvd;
        logic [2:0]  attr_idx;
        logic        en;
    } lim_word_t;

    function automatic logic [7:0] attr_pick(input logic [31:0] lo_word,
                                             input logic [31:0] hi_word,
                                             input logic [2:0]  idx);
        logic [63:0] both;
        both = {hi_word, lo_word};
        return both[{idx, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/prot_regfile.sv
module prot_regfile
    import prot_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_wr,
    input  logic [7:0]                   reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    output ctrl_t                        ctrl_o,
    output base_word_t [NUM_REGIONS-1:0] base_o,
    output lim_word_t  [NUM_REGIONS-1:0] lim_o,
    output logic [31:0]                  attr_lo_o,
    output logic [31:0]                  attr_hi_o
);
    localparam int IDX_W = $clog2(NUM_REGIONS);
    localparam logic [31:0] TYPE_WORD = {16'h0, 8'(NUM_REGIONS), 8'h00};

    ctrl_t                        ctrl_q;
    logic [IDX_W-1:0]             sel_q;
    base_word_t [NUM_REGIONS-1:0] base_q;
    lim_word_t  [NUM_REGIONS-1:0] lim_q;
    logic [31:0]                  attr_lo_q;
    logic [31:0]                  attr_hi_q;

    logic [5:0]       word;
    logic             in_win;
    logic [5:0]       kslot;
    logic [1:0]       alias_n;
    logic             is_lim;
    logic [IDX_W-1:0] tgt;

    always_comb begin
        word    = reg_addr[7:2];
        in_win  = (word >= 6'd3) && (word <= 6'd10);
        kslot   = word - 6'd3;
        alias_n = kslot[2:1];
        is_lim  = kslot[0];
        tgt     = (alias_n == 2'd0) ? sel_q : {sel_q[IDX_W-1:2], alias_n};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            sel_q     <= '0;
            base_q    <= '0;
            lim_q     <= '0;
            attr_lo_q <= '0;
            attr_hi_q <= '0;
        end else if (reg_wr) begin
            case (word)
                6'd1:  ctrl_q    <= ctrl_t'(reg_wdata[2:0]);
                6'd2:  sel_q     <= reg_wdata[IDX_W-1:0];
                6'd12: attr_lo_q <= reg_wdata;
                6'd13: attr_hi_q <= reg_wdata;
                default: begin
                    if (in_win) begin
                        if (is_lim) lim_q[tgt]  <= lim_word_t'(reg_wdata & LIM_WMASK);
                        else        base_q[tgt] <= base_word_t'(reg_wdata);
                    end
                end
            endcase
        end
    end

    always_comb begin
        case (word)
            6'd0:    reg_rdata = TYPE_WORD;
            6'd1:    reg_rdata = {29'b0, ctrl_q};
            6'd2:    reg_rdata = 32'(sel_q);
            6'd12:   reg_rdata = attr_lo_q;
            6'd13:   reg_rdata = attr_hi_q;
            default: reg_rdata = in_win ? (is_lim ? 32'(lim_q[tgt]) : 32'(base_q[tgt])) : 32'h0;
        endcase
    end

    assign ctrl_o    = ctrl_q;
    assign base_o    = base_q;
    assign lim_o     = lim_q;
    assign attr_lo_o = attr_lo_q;
    assign attr_hi_o = attr_hi_q;

    AST_TYPE_FIXED: assert property (@(posedge clk) disable iff (rst)
        (word == 6'd0) |-> (reg_rdata == TYPE_WORD)); // R1
    AST_CTRL_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && word == 6'd1) |=> (ctrl_o == ctrl_t'($past(reg_wdata[2:0])))); // R2
    AST_SEL_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && word == 6'd2) |=> (sel_q == $past(reg_wdata[IDX_W-1:0]))); // R3
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && word == 6'd1) |=> $stable(ctrl_o)); // R13

endmodule

// File: rtl/prot_region_match.sv
module prot_region_match
    import prot_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic [31:0]                  acc_addr,
    input  base_word_t [NUM_REGIONS-1:0] base_i,
    input  lim_word_t  [NUM_REGIONS-1:0] lim_i,
    output logic [NUM_REGIONS-1:0]       match_o
);
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
        logic [31:0] lo_addr;
        logic [31:0] hi_addr;
        assign lo_addr    = {base_i[r].bound, 5'b00000};
        assign hi_addr    = {lim_i[r].bound, 5'b11111};
        assign match_o[r] = lim_i[r].en && (acc_addr >= lo_addr) && (acc_addr <= hi_addr);
    end
endmodule

// File: rtl/prot_decide.sv
module prot_decide
    import prot_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  ctrl_t                        ctrl_i,
    input  logic [NUM_REGIONS-1:0]       match_i,
    input  base_word_t [NUM_REGIONS-1:0] base_i,
    input  lim_word_t  [NUM_REGIONS-1:0] lim_i,
    input  logic [31:0]                  attr_lo_i,
    input  logic [31:0]                  attr_hi_i,
    input  logic                         acc_priv,
    input  logic                         acc_write,
    input  logic                         acc_fetch,
    input  logic                         acc_negpri,
    output logic                         acc_fault,
    output logic                         acc_hit,
    output logic [$clog2(NUM_REGIONS)-1:0] acc_region,
    output logic [7:0]                   acc_attr
);
    localparam int IDX_W = $clog2(NUM_REGIONS);
    localparam int CNT_W = $clog2(NUM_REGIONS + 1);

    logic [CNT_W-1:0] n_hit;
    logic [IDX_W-1:0] first;
    logic             bypass;
    logic             perm_bad;
    base_word_t       sel_base;
    lim_word_t        sel_lim;

    always_comb begin
        n_hit = '0;
        first = '0;
        for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
            if (match_i[r]) begin
                n_hit = n_hit + CNT_W'(1);
                first = IDX_W'(r);
            end
        end
        bypass   = !ctrl_i.en || (acc_negpri && !ctrl_i.neg_en);
        sel_base = base_i[first];
        sel_lim  = lim_i[first];
        perm_bad = (acc_write && sel_base.perm[1]) ||
                   (!acc_priv && !sel_base.perm[0]) ||
                   (acc_fetch && sel_base.xn);

        acc_fault  = 1'b0;
        acc_hit    = 1'b0;
        acc_region = '0;
        acc_attr   = 8'h00;
        if (!bypass) begin
            if (n_hit == '0) begin
                acc_fault = !(acc_priv && ctrl_i.priv_bg);
            end else if (n_hit == CNT_W'(1)) begin
                acc_hit    = 1'b1;
                acc_region = first;
                acc_attr   = attr_pick(attr_lo_i, attr_hi_i, sel_lim.attr_idx);
                acc_fault  = perm_bad;
            end else begin
                acc_fault = 1'b1;
            end
        end
    end

    AST_OFF_OPEN: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.en |-> (!acc_fault && !acc_hit && acc_attr == 8'h00)); // R8
    AST_NEG_OPEN: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.en && acc_negpri && !ctrl_i.neg_en) |-> (!acc_fault && !acc_hit)); // R9
    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        acc_hit |-> ($countones(match_i) == 1)); // R11
    AST_HIT_REGION: assert property (@(posedge clk) disable iff (rst)
        acc_hit |-> match_i[acc_region]); // R7
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_hit |-> (acc_attr == 8'h00 && acc_region == '0)); // R10

endmodule

// File: rtl/prot_region_unit.sv
module prot_region_unit
    import prot_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] acc_addr,
    input  logic        acc_priv,
    input  logic        acc_write,
    input  logic        acc_fetch,
    input  logic        acc_negpri,
    output logic        acc_fault,
    output logic        acc_hit,
    output logic [2:0]  acc_region,
    output logic [7:0]  acc_attr
);
    ctrl_t                        ctrl_w;
    base_word_t [NUM_REGIONS-1:0] base_w;
    lim_word_t  [NUM_REGIONS-1:0] lim_w;
    logic [31:0]                  attr_lo_w;
    logic [31:0]                  attr_hi_w;
    logic [NUM_REGIONS-1:0]       match_w;

    prot_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl_o    (ctrl_w),
        .base_o    (base_w),
        .lim_o     (lim_w),
        .attr_lo_o (attr_lo_w),
        .attr_hi_o (attr_hi_w)
    );

    prot_region_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
        .acc_addr (acc_addr),
        .base_i   (base_w),
        .lim_i    (lim_w),
        .match_o  (match_w)
    );

    prot_decide #(.NUM_REGIONS(NUM_REGIONS)) u_decide (
        .clk        (clk),
        .rst        (rst),
        .ctrl_i     (ctrl_w),
        .match_i    (match_w),
        .base_i     (base_w),
        .lim_i      (lim_w),
        .attr_lo_i  (attr_lo_w),
        .attr_hi_i  (attr_hi_w),
        .acc_priv   (acc_priv),
        .acc_write  (acc_write),
        .acc_fetch  (acc_fetch),
        .acc_negpri (acc_negpri),
        .acc_fault  (acc_fault),
        .acc_hit    (acc_hit),
        .acc_region (acc_region),
        .acc_attr   (acc_attr)
    );
endmodule

// File: tb/sim_prot_region_unit.sv
module sim_prot_region_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_priv = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_fetch = 1'b0;
    logic        acc_negpri = 1'b0;
    logic        acc_fault;
    logic        acc_hit;
    logic [2:0]  acc_region;
    logic [7:0]  acc_attr;

    int n_chk = 0;
    int n_bad = 0;

    // bench-side model of the register state
    logic [31:0] m_base [8];
    logic [31:0] m_lim  [8];
    logic [2:0]  m_ctrl;
    logic [2:0]  m_sel;
    logic [31:0] m_attr0;
    logic [31:0] m_attr1;

    always #4 clk = ~clk;

    prot_region_unit u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
        .acc_priv(acc_priv), .acc_write(acc_write), .acc_fetch(acc_fetch),
        .acc_negpri(acc_negpri), .acc_fault(acc_fault), .acc_hit(acc_hit),
        .acc_region(acc_region), .acc_attr(acc_attr)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        finish_run();
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void m_reset();
        for (int r = 0; r < 8; r++) begin m_base[r] = 0; m_lim[r] = 0; end
        m_ctrl = 0; m_sel = 0; m_attr0 = 0; m_attr1 = 0;
    endfunction

    function automatic void m_write(input logic [7:0] off, input logic [31:0] d);
        int k;
        logic [2:0] r;
        case (off)
            8'h04: m_ctrl = d[2:0];
            8'h08: m_sel = d[2:0];
            8'h30: m_attr0 = d;
            8'h34: m_attr1 = d;
            default: begin
                if (off >= 8'h0C && off <= 8'h28) begin
                    k = (int'(off) - 12) / 4;
                    r = (k / 2 == 0) ? m_sel : {m_sel[2], 2'(k / 2)};
                    if (k % 2 == 1) m_lim[r] = d & 32'hFFFF_FFEF;
                    else            m_base[r] = d;
                end
            end
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] off);
        int k;
        logic [2:0] r;
        case (off)
            8'h00: return 32'h0000_0800;
            8'h04: return {29'b0, m_ctrl};
            8'h08: return {29'b0, m_sel};
            8'h30: return m_attr0;
            8'h34: return m_attr1;
            default: begin
                if (off >= 8'h0C && off <= 8'h28) begin
                    k = (int'(off) - 12) / 4;
                    r = (k / 2 == 0) ? m_sel : {m_sel[2], 2'(k / 2)};
                    return (k % 2 == 1) ? m_lim[r] : m_base[r];
                end
                return 32'h0;
            end
        endcase
    endfunction

    // {fault, hit, region[2:0], attr[7:0]}
    function automatic logic [12:0] m_look(input logic [31:0] a, input logic p,
                                           input logic w, input logic f, input logic ng);
        int cnt;
        logic [2:0] idx;
        logic [63:0] both;
        logic [2:0] ai;
        logic flt;
        if (!m_ctrl[0] || (ng && !m_ctrl[1])) return 13'h0;
        cnt = 0; idx = 0;
        for (int r = 0; r < 8; r++) begin
            if (m_lim[r][0] && a >= (m_base[r] & 32'hFFFF_FFE0) && a <= (m_lim[r] | 32'h1F)) begin
                cnt++; idx = 3'(r);
            end
        end
        if (cnt == 0) return {!(p && m_ctrl[2]), 12'h0};
        if (cnt > 1)  return {1'b1, 12'h0};
        both = {m_attr1, m_attr0};
        ai   = m_lim[idx][3:1];
        flt  = (w && m_base[idx][2]) || (!p && !m_base[idx][1]) || (f && m_base[idx][0]);
        return {flt, 1'b1, idx, both[ai*8 +: 8]};
    endfunction

    task automatic wr(input logic [7:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = off; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        m_write(off, d);
    endtask

    task automatic rd(input string tag, input logic [7:0] off);
        @(negedge clk);
        reg_addr = off;
        #1;
        check(tag, reg_rdata, m_read(off));
    endtask

    task automatic look(input string tag, input logic [31:0] a, input logic p,
                        input logic w, input logic f, input logic ng);
        @(negedge clk);
        acc_addr = a; acc_priv = p; acc_write = w; acc_fetch = f; acc_negpri = ng;
        #1;
        check(tag, {19'b0, acc_fault, acc_hit, acc_region, acc_attr}, {19'b0, m_look(a, p, w, f, ng)});
    endtask

    // program window r via the primary pair or its alias pair (R5)
    task automatic program_win(input logic [2:0] r, input logic [31:0] bw, input logic [31:0] lw);
        logic [7:0] boff;
        if (r[1:0] != 2'd0 && $urandom_range(0, 1) == 1) begin
            wr(8'h08, {29'b0, r[2], 2'($urandom_range(0, 3))});
            boff = 8'h0C + 8'(r[1:0]) * 8'h08;
        end else begin
            wr(8'h08, {29'b0, r});
            boff = 8'h0C;
        end
        wr(boff, bw);
        wr(boff + 8'h04, lw);
    endtask

    initial begin
        void'($urandom(32'd2024));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of the whole map
        for (int o = 0; o < 16; o++) rd("R1 reset read", 8'(o * 4));
        wr(8'h00, 32'hFFFF_FFFF);
        rd("R1 type ignores write", 8'h00);

        // R13: unmapped offsets
        wr(8'h2C, 32'hDEAD_BEEF);
        wr(8'h38, 32'h1234_5678);
        rd("R13 hole 0x2C", 8'h2C);
        rd("R13 beyond 0x38", 8'h38);
        for (int o = 0; o < 14; o++) rd("R13 no side effect", 8'(o * 4));

        // R2, R3: reserved bits
        wr(8'h04, 32'hFFFF_FFFF);
        rd("R2 control reserved bits", 8'h04);
        wr(8'h08, 32'hFFFF_FFFF);
        rd("R3 selector reserved bits", 8'h08);

        // R4: field storage, limit bit 4 reads zero
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        rd("R4 base word", 8'h0C);
        rd("R4 limit word", 8'h10);

        // R5: aliases with selector 5 reach windows 5, 6, 7; selector 2 alias1 reaches 1
        wr(8'h08, 32'd5);
        wr(8'h14, 32'h0000_2002);
        wr(8'h1C, 32'h0000_3002);
        wr(8'h24, 32'h0000_4002);
        wr(8'h08, 32'd2);
        wr(8'h18, 32'h0000_1103);
        for (int r = 0; r < 8; r++) begin
            wr(8'h08, r);
            rd("R5 alias target base", 8'h0C);
            rd("R5 alias target limit", 8'h10);
        end

        // clear and set one clean window 0 for directed lookups
        for (int r = 0; r < 8; r++) program_win(3'(r), 32'h0, 32'h0);
        wr(8'h30, 32'h4433_2211);
        wr(8'h34, 32'h8877_6655);
        program_win(3'd0, 32'h0000_1002, 32'h0000_10E5);
        wr(8'h04, 32'h1);

        // R7: inclusive bounds
        look("R7 below base", 32'h0000_0FFF, 1'b1, 1'b0, 1'b0, 1'b0);
        look("R7 at base", 32'h0000_1000, 1'b1, 1'b0, 1'b0, 1'b0);
        look("R7 at limit", 32'h0000_10FF, 1'b0, 1'b1, 1'b0, 1'b0);
        look("R7 past limit", 32'h0000_1100, 1'b1, 1'b0, 1'b0, 1'b0);

        // R6: every attribute index
        for (int k = 0; k < 8; k++) begin
            program_win(3'd0, 32'h0000_1002, 32'h0000_10E1 | (k << 1));
            look("R6 attribute index", 32'h0000_1040, 1'b1, 1'b0, 1'b0, 1'b0);
        end

        // R12: permissions and execute-never
        program_win(3'd0, 32'h0000_1004, 32'h0000_10E1);
        look("R12 write to read-only", 32'h0000_1010, 1'b1, 1'b1, 1'b0, 1'b0);
        look("R12 unprivileged to privileged-only", 32'h0000_1010, 1'b0, 1'b0, 1'b0, 1'b0);
        program_win(3'd0, 32'h0000_1003, 32'h0000_10E1);
        look("R12 fetch from execute-never", 32'h0000_1010, 1'b1, 1'b0, 1'b1, 1'b0);
        look("R12 read allowed", 32'h0000_1010, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10: miss with and without fallback
        look("R10 miss no fallback", 32'h0000_9000, 1'b1, 1'b0, 1'b0, 1'b0);
        wr(8'h04, 32'h5);
        look("R10 miss privileged fallback", 32'h0000_9000, 1'b1, 1'b0, 1'b0, 1'b0);
        look("R10 miss unprivileged", 32'h0000_9000, 1'b0, 1'b0, 1'b0, 1'b0);

        // R11: overlap
        program_win(3'd3, 32'h0000_1082, 32'h0000_1201);
        look("R11 overlap faults", 32'h0000_10A0, 1'b1, 1'b0, 1'b0, 1'b0);
        look("R11 single in second window", 32'h0000_1180, 1'b1, 1'b0, 1'b0, 1'b0);

        // R9: negative priority
        look("R9 negpri bypass", 32'h0000_10A0, 1'b1, 1'b0, 1'b0, 1'b1);
        wr(8'h04, 32'h3);
        look("R9 negpri checked", 32'h0000_10A0, 1'b1, 1'b0, 1'b0, 1'b1);

        // R8: disabled
        wr(8'h04, 32'h6);
        look("R8 disabled overlap", 32'h0000_10A0, 1'b0, 1'b1, 1'b1, 1'b0);
        look("R8 disabled miss", 32'h0000_9000, 1'b0, 1'b0, 1'b0, 1'b0);

        // random configurations (R5, R6, R7, R10, R11, R12)
        for (int round = 0; round < 12; round++) begin
            for (int r = 0; r < 8; r++) begin
                logic [31:0] lo;
                logic [31:0] bw;
                logic [31:0] lw;
                lo = 32'($urandom_range(0, 63)) << 5;
                bw = lo | 32'($urandom_range(0, 31));
                lw = (lo + (32'($urandom_range(0, 12)) << 5)) | 32'($urandom_range(0, 15));
                if ($urandom_range(0, 3) == 0) lw = lw & 32'hFFFF_FFFE;
                program_win(3'(r), bw, lw);
            end
            wr(8'h30, $urandom);
            wr(8'h34, $urandom);
            wr(8'h04, {29'b0, 3'($urandom_range(0, 7)) | 3'b001});
            for (int o = 0; o < 4; o++) rd("R4 R5 random readback", 8'(8'h0C + 8'($urandom_range(0, 7)) * 8'h04));
            for (int i = 0; i < 60; i++) begin
                look("R7 R11 R12 random lookup", 32'($urandom_range(0, 32'h0A00)),
                     1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 5) == 0));
            end
        end

        finish_run();
    end
endmodule